// File: doc/BRIEF.md
# IDE PIO cycle timing generator

This block sequences programmed I/O cycles on one parallel ATA channel. A host raises a request naming the target drive (master or slave), the direction, the width (16-bit word or 8-bit byte), a register address and, for writes, the data. The block then runs three phases. In the setup phase, chip select and address are driven while both strobes stay high. In the active phase, the read or write strobe is low. In the recovery phase, chip select and strobes are released before the next access may begin.

Each phase length comes from a 4-bit clock count held in configuration registers, which are written over a small dword register bus with byte enables. Every drive has its own setup count and three timing bytes: one for 16-bit reads, one for 16-bit writes, and one shared by 8-bit reads and writes. Both drives' setup counts share a single register. A count of n stretches its phase to n+1 bus clocks. Counts are latched when an access starts, so configuration writes made during an access have no effect on it.

Top module: `ata_pio_timer`

## Requirements
- R1: After reset, every timing and setup field is 0xF. Dword 0x48 reads 0x000000FF, dword 0x4C reads 0xFFFFFFFF and dword 0x50 reads 0x0000FFFF. Both strobes and both chip selects are high and ack is low.
- R2: Register map, byte addressed with dword reads. In dword 0x48, bits [3:0] hold the master setup count and bits [7:4] the slave setup count. In dword 0x4C, bits [7:0] are master 16-bit read, [15:8] master 16-bit write, [23:16] slave 16-bit read and [31:24] slave 16-bit write. In dword 0x50, bits [7:0] are master 8-bit and [15:8] slave 8-bit. In every timing byte, bits [7:4] are the active count and bits [3:0] the recovery count. Unmapped bits and unmapped addresses read 0.
- R3: A write changes only the bytes whose cfg_be bit is set. Writes to unmapped bytes or addresses change nothing, so a drive's setup nibble is changed only through byte 0 of dword 0x48.
- R4: The setup phase drives the chip select chosen by req_addr[3] (0 selects ata_cs0_n, 1 selects ata_cs1_n) and drives ata_da = req_addr[2:0], with both strobes high, for setup+1 clocks. The setup count is taken from the drive named by req_drive (0 = master).
- R5: The active phase holds exactly one strobe low for active+1 clocks: ata_dior_n for reads and ata_diow_n for writes. The timing byte is chosen by req_drive, req_write and req_wide (1 = 16-bit).
- R6: After the active phase, chip selects and strobes stay released for recovery+1 clocks. A request that is present during recovery starts its setup phase only after recovery ends.
- R7: ack is high for exactly one clock: the first clock after the last active clock. rd_data then holds ata_dd_in as sampled on the last active clock, with the upper byte forced to zero for 8-bit reads.
- R8: For writes, ata_dd_oe is high and ata_dd_out carries req_wdata (upper byte zero for 8-bit writes) throughout setup and active. ata_dd_oe is never high during a read.
- R9: Setup, active and recovery counts are captured at the start of an access. Configuration writes made during the access do not affect it.
- R10: ata_dior_n and ata_diow_n are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address (dword aligned) |
| cfg_be | input | 4 | Configuration byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr |
| req | input | 1 | Access request, held until ack |
| req_drive | input | 1 | 0 master, 1 slave |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 1 for 16-bit, 0 for 8-bit |
| req_addr | input | 4 | [3] chip select choice, [2:0] device address |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Captured read data |
| ata_cs0_n | output | 1 | Chip select 0, active low |
| ata_cs1_n | output | 1 | Chip select 1, active low |
| ata_da | output | 3 | Device address |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | 16 | Data driven to the drive |
| ata_dd_oe | output | 1 | Data output enable |
| ata_dd_in | input | 16 | Data from the drive |

## Verification
The bench builds the block with its default 16-bit data path and 3-bit device address, so every phase count from 0 to 15 fits into short runs. It sweeps each count value through all eight combinations of drive, direction and width. Back-to-back accesses with the request held high expose the recovery gap, and a configuration rewrite during an access exposes the latching of counts.

// File: rtl/ata_pio_pkg.sv
`timescale 1ns/1ps
package ata_pio_pkg;
  localparam int FIELD_W = 4;
  localparam int TBYTE_W = 2 * FIELD_W;
  localparam int CFG_W   = 32;
  localparam int N_KINDS = 3;

  // dword indices (byte address >> 2)
  localparam logic [5:0] DW_SETUP = 6'h12;
  localparam logic [5:0] DW_T16   = 6'h13;
  localparam logic [5:0] DW_T8    = 6'h14;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACTIVE, PH_RECOV} pio_phase_e;
  typedef enum logic [1:0] {KIND_RD16 = 2'd0, KIND_WR16 = 2'd1, KIND_BYTE = 2'd2} xfer_kind_e;

  typedef struct packed {
    logic [FIELD_W-1:0] act;
    logic [FIELD_W-1:0] rec;
  } tbyte_t;
endpackage

// File: rtl/pio_rst_sync.sv
`timescale 1ns/1ps
module pio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pio_timing_regs.sv
`timescale 1ns/1ps
module pio_timing_regs
  import ata_pio_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [7:0]          cfg_addr,
  input  logic [3:0]          cfg_be,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic [CFG_W-1:0]    cfg_rdata,
  input  logic                sel_drive,
  input  xfer_kind_e          sel_kind,
  output logic [FIELD_W-1:0]  sel_setup,
  output tbyte_t              sel_tbyte
);
  localparam int N_DRV = 2;

  logic [N_DRV-1:0][FIELD_W-1:0]      setup_q, setup_d;
  tbyte_t [N_DRV-1:0][N_KINDS-1:0]    tim_q, tim_d;
  logic hit_setup, hit_t16, hit_t8, wr_en;

  assign hit_setup = cfg_we && (cfg_addr[7:2] == DW_SETUP);
  assign hit_t16   = cfg_we && (cfg_addr[7:2] == DW_T16);
  assign hit_t8    = cfg_we && (cfg_addr[7:2] == DW_T8);
  assign wr_en     = hit_setup || hit_t16 || hit_t8;

  always_comb begin
    setup_d = setup_q;
    tim_d   = tim_q;
    if (hit_setup && cfg_be[0]) setup_d = cfg_wdata[2*FIELD_W-1:0];
    for (int d = 0; d < N_DRV; d++) begin
      if (hit_t16 && cfg_be[2*d])   tim_d[d][int'(KIND_RD16)] = cfg_wdata[16*d +: TBYTE_W];
      if (hit_t16 && cfg_be[2*d+1]) tim_d[d][int'(KIND_WR16)] = cfg_wdata[16*d+8 +: TBYTE_W];
      if (hit_t8  && cfg_be[d])     tim_d[d][int'(KIND_BYTE)] = cfg_wdata[8*d +: TBYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= '1;
      tim_q   <= '1;
    end else if (wr_en) begin
      setup_q <= setup_d;
      tim_q   <= tim_d;
    end
  end

  always_comb begin
    case (cfg_addr[7:2])
      DW_SETUP: cfg_rdata = {{(CFG_W-2*FIELD_W){1'b0}}, setup_q};
      DW_T16:   cfg_rdata = {tim_q[1][int'(KIND_WR16)], tim_q[1][int'(KIND_RD16)],
                             tim_q[0][int'(KIND_WR16)], tim_q[0][int'(KIND_RD16)]};
      DW_T8:    cfg_rdata = {16'h0, tim_q[1][int'(KIND_BYTE)], tim_q[0][int'(KIND_BYTE)]};
      default:  cfg_rdata = '0;
    endcase
  end

  assign sel_setup = setup_q[sel_drive];

  always_comb begin
    case (sel_kind)
      KIND_RD16: sel_tbyte = tim_q[sel_drive][int'(KIND_RD16)];
      KIND_WR16: sel_tbyte = tim_q[sel_drive][int'(KIND_WR16)];
      default:   sel_tbyte = tim_q[sel_drive][int'(KIND_BYTE)];
    endcase
  end

  // R3: setup nibbles move only on an enabled write to byte 0 of the setup dword
  p_setup_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_addr[7:2] == DW_SETUP && cfg_be[0]) |=> $stable(setup_q));
endmodule

// File: rtl/pio_access_seq.sv
`timescale 1ns/1ps
module pio_access_seq
  import ata_pio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               req_write,
  input  logic               req_wide,
  input  logic [ADDR_W:0]    req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [FIELD_W-1:0] cfg_setup,
  input  tbyte_t             cfg_tbyte,
  output logic               ack,
  output logic [DATA_W-1:0]  rd_data,
  output logic               ata_cs0_n,
  output logic               ata_cs1_n,
  output logic [ADDR_W-1:0]  ata_da,
  output logic               ata_dior_n,
  output logic               ata_diow_n,
  output logic [DATA_W-1:0]  ata_dd_out,
  output logic               ata_dd_oe,
  input  logic [DATA_W-1:0]  ata_dd_in
);
  localparam int NARROW_W = 8;
  localparam int PAD_W    = DATA_W - NARROW_W;

  pio_phase_e         phase_q, phase_d;
  logic [FIELD_W-1:0] cnt_q, cnt_d, act_q, rec_q;
  logic               write_q, wide_q, ack_q, ack_d;
  logic [ADDR_W:0]    addr_q;
  logic [DATA_W-1:0]  wdata_q, rdata_q, rdata_d, wdata_fmt;
  logic               start, capture, cnt_zero, addr_phase;

  assign cnt_zero  = (cnt_q == '0);
  assign start     = req && ((phase_q == PH_IDLE) || (phase_q == PH_RECOV && cnt_zero));
  assign capture   = (phase_q == PH_ACTIVE) && cnt_zero && !write_q;
  assign wdata_fmt = req_wide ? req_wdata : {{PAD_W{1'b0}}, req_wdata[NARROW_W-1:0]};
  assign rdata_d   = wide_q ? ata_dd_in : {{PAD_W{1'b0}}, ata_dd_in[NARROW_W-1:0]};

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    ack_d   = 1'b0;
    case (phase_q)
      PH_SETUP: begin
        if (cnt_zero) begin phase_d = PH_ACTIVE; cnt_d = act_q; end
        else          cnt_d = cnt_q - 1'b1;
      end
      PH_ACTIVE: begin
        if (cnt_zero) begin phase_d = PH_RECOV; cnt_d = rec_q; ack_d = 1'b1; end
        else          cnt_d = cnt_q - 1'b1;
      end
      PH_RECOV: begin
        if (cnt_zero) phase_d = PH_IDLE;
        else          cnt_d = cnt_q - 1'b1;
      end
      default: ;
    endcase
    if (start) begin
      phase_d = PH_SETUP;
      cnt_d   = cfg_setup;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      ack_q   <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= '1;
      rec_q   <= '1;
      write_q <= 1'b0;
      wide_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      act_q   <= cfg_tbyte.act;
      rec_q   <= cfg_tbyte.rec;
      write_q <= req_write;
      wide_q  <= req_wide;
      addr_q  <= req_addr;
      wdata_q <= wdata_fmt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= rdata_d;
  end

  assign addr_phase = (phase_q == PH_SETUP) || (phase_q == PH_ACTIVE);
  assign ata_cs0_n  = !(addr_phase && !addr_q[ADDR_W]);
  assign ata_cs1_n  = !(addr_phase &&  addr_q[ADDR_W]);
  assign ata_da     = addr_phase ? addr_q[ADDR_W-1:0] : '0;
  assign ata_dior_n = !((phase_q == PH_ACTIVE) && !write_q);
  assign ata_diow_n = !((phase_q == PH_ACTIVE) &&  write_q);
  assign ata_dd_oe  = addr_phase && write_q;
  assign ata_dd_out = wdata_q;
  assign ack        = ack_q;
  assign rd_data    = rdata_q;

  // R10: strobes mutually exclusive
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_dior_n && !ata_diow_n));
  // R5: a strobe is only ever low under exactly one chip select
  p_strobe_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_dior_n || !ata_diow_n) |-> (ata_cs0_n != ata_cs1_n));
  // R4: a strobe falls only after a cycle with chip select already asserted
  p_setup_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ata_dior_n && ata_diow_n) |-> $past(!ata_cs0_n || !ata_cs1_n));
  // R7: ack is a single clock and follows an active strobe
  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  p_ack_after_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(!ata_dior_n || !ata_diow_n));
  // R8: bus never driven while reading
  p_oe_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ata_dd_oe |-> ata_dior_n);
endmodule

// File: rtl/ata_pio_timer.sv
`timescale 1ns/1ps
module ata_pio_timer
  import ata_pio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req,
  input  logic              req_drive,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W:0]   req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              ata_cs0_n,
  output logic              ata_cs1_n,
  output logic [ADDR_W-1:0] ata_da,
  output logic              ata_dior_n,
  output logic              ata_diow_n,
  output logic [DATA_W-1:0] ata_dd_out,
  output logic              ata_dd_oe,
  input  logic [DATA_W-1:0] ata_dd_in
);
  logic               rst_int_n;
  xfer_kind_e         kind;
  logic [FIELD_W-1:0] sel_setup;
  tbyte_t             sel_tbyte;

  assign kind = !req_wide ? KIND_BYTE : (req_write ? KIND_WR16 : KIND_RD16);

  pio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  pio_timing_regs u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .sel_drive(req_drive), .sel_kind(kind),
    .sel_setup(sel_setup), .sel_tbyte(sel_tbyte)
  );

  pio_access_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .req(req), .req_write(req_write), .req_wide(req_wide),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_setup(sel_setup), .cfg_tbyte(sel_tbyte),
    .ack(ack), .rd_data(rd_data),
    .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n), .ata_da(ata_da),
    .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
    .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe), .ata_dd_in(ata_dd_in)
  );
endmodule

// File: tb/test_ata_pio_timer.sv
`timescale 1ns/1ps
module test_ata_pio_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cfg_we = 0;
  logic [7:0]  cfg_addr = 0;
  logic [3:0]  cfg_be = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic        req = 0, req_drive = 0, req_write = 0, req_wide = 0;
  logic [3:0]  req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic        ack;
  logic [15:0] rd_data;
  logic        ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_dd_oe;
  logic [2:0]  ata_da;
  logic [15:0] ata_dd_out;
  logic [15:0] ata_dd_in = 0;

  ata_pio_timer i_ata_pio_timer (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req(req), .req_drive(req_drive), .req_write(req_write), .req_wide(req_wide),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .ack(ack), .rd_data(rd_data),
    .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n), .ata_da(ata_da),
    .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
    .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe), .ata_dd_in(ata_dd_in)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // bench-side model of the configuration
  logic [3:0] sh_setup [2];
  logic [7:0] sh_t [2][3];

  function automatic logic [31:0] model_rd(input logic [7:0] a);
    case (a[7:2])
      6'h12:   return {24'h0, sh_setup[1], sh_setup[0]};
      6'h13:   return {sh_t[1][1], sh_t[1][0], sh_t[0][1], sh_t[0][0]};
      6'h14:   return {16'h0, sh_t[1][2], sh_t[0][2]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    case (a[7:2])
      6'h12: if (be[0]) begin sh_setup[0] = d[3:0]; sh_setup[1] = d[7:4]; end
      6'h13: begin
        if (be[0]) sh_t[0][0] = d[7:0];
        if (be[1]) sh_t[0][1] = d[15:8];
        if (be[2]) sh_t[1][0] = d[23:16];
        if (be[3]) sh_t[1][1] = d[31:24];
      end
      6'h14: begin
        if (be[0]) sh_t[0][2] = d[7:0];
        if (be[1]) sh_t[1][2] = d[15:8];
      end
      default: ;
    endcase
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    model_wr(a, be, d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_rd_chk(input logic [7:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    cfg_addr = a;
    #1;
    e = model_rd(a);
    chk(cfg_rdata == e, tag, cfg_rdata, e);
  endtask

  // configuration rewrite during an access (R9)
  bit          mid_on = 0;
  int          mid_cyc = 0;
  logic [31:0] mid_setup = 0, mid_tval = 0;
  logic [7:0]  mid_taddr = 0;

  function automatic bit cs_on();
    return !ata_cs0_n || !ata_cs1_n;
  endfunction

  task automatic step();
    if (mid_on && (mid_cyc > 0 || cs_on())) begin
      case (mid_cyc)
        0: begin cfg_we = 1; cfg_addr = 8'h48; cfg_be = 4'h1; cfg_wdata = mid_setup;
                 model_wr(8'h48, 4'h1, mid_setup); end
        1: begin cfg_addr = mid_taddr; cfg_be = 4'hF; cfg_wdata = mid_tval;
                 model_wr(mid_taddr, 4'hF, mid_tval); end
        default: begin cfg_we = 0; mid_on = 0; end
      endcase
      mid_cyc++;
    end
    @(negedge clk);
  endtask

  // two back-to-back accesses with the request held high
  task automatic access(input bit d, input bit w, input bit wide, input logic [3:0] a,
                        input logic [15:0] wd, input logic [15:0] di);
    int k, s, ac, r, n;
    logic [15:0] exp_out, exp_rd;
    k = wide ? (w ? 1 : 0) : 2;
    exp_out = wide ? wd : {8'h0, wd[7:0]};
    exp_rd  = wide ? di : {8'h0, di[7:0]};
    @(negedge clk);
    req = 1; req_drive = d; req_write = w; req_wide = wide; req_addr = a;
    req_wdata = wd; ata_dd_in = di;
    n = 0;
    while (!cs_on() && n < 40) begin n++; step(); end
    for (int pass = 0; pass < 2; pass++) begin
      s  = sh_setup[d];
      ac = sh_t[d][k][7:4];
      r  = sh_t[d][k][3:0];
      n = 0;
      while (cs_on() && ata_dior_n && ata_diow_n && n < 40) begin
        chk(ata_cs0_n == a[3] && ata_cs1_n == !a[3] && ata_da == a[2:0], "R4 address/select",
            {ata_cs1_n, ata_cs0_n, ata_da}, {!a[3], a[3], a[2:0]});
        chk(ata_dd_oe == w && (!w || ata_dd_out == exp_out), "R8 data drive in setup",
            {ata_dd_oe, ata_dd_out}, {w, exp_out});
        n++; step();
      end
      chk(n == s + 1, "R4 setup clocks", n, s + 1);
      n = 0;
      while ((!ata_dior_n || !ata_diow_n) && n < 40) begin
        chk(ata_dior_n == w && ata_diow_n == !w, "R5/R10 strobe choice",
            {ata_dior_n, ata_diow_n}, {w, !w});
        chk(ata_cs0_n == a[3] && ata_cs1_n == !a[3] && ata_da == a[2:0], "R4 address held",
            {ata_cs1_n, ata_cs0_n, ata_da}, {!a[3], a[3], a[2:0]});
        chk(ata_dd_oe == w && (!w || ata_dd_out == exp_out), "R8 data drive in active",
            {ata_dd_oe, ata_dd_out}, {w, exp_out});
        chk(ack == 0, "R7 no early ack", ack, 0);
        n++; step();
      end
      chk(n == ac + 1, "R5 active clocks", n, ac + 1);
      chk(ack == 1, "R7 ack after active", ack, 1);
      chk(!cs_on() && ata_dior_n && ata_diow_n, "R6 released in recovery",
          {ata_cs0_n, ata_cs1_n}, 2'b11);
      if (!w) chk(rd_data == exp_rd, "R7 read data", rd_data, exp_rd);
      if (pass == 1) begin
        req = 0;
      end else begin
        step();
        n = 1;
        while (!cs_on() && n < 40) begin
          chk(ack == 0, "R7 single ack", ack, 0);
          n++; step();
        end
        chk(n == r + 1, "R6 recovery clocks", n, r + 1);
      end
    end
    repeat (18) @(negedge clk);
  endtask

  bit done = 0;

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      sh_setup[d] = 4'hF;
      for (int k = 0; k < 3; k++) sh_t[d][k] = 8'hFF;
    end
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    chk(ata_cs0_n && ata_cs1_n && ata_dior_n && ata_diow_n && !ack && !ata_dd_oe,
        "R1 idle outputs in reset", {ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ack}, 5'b11110);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R1: reset values of all fields
    cfg_rd_chk(8'h48, "R1 setup reset");
    cfg_rd_chk(8'h4C, "R1 16-bit timing reset");
    cfg_rd_chk(8'h50, "R1 8-bit timing reset");
    chk(cfg_rdata == 32'h0000FFFF, "R1 8-bit dword literal", cfg_rdata, 32'h0000FFFF);

    // R2: full map with distinct values
    cfg_wr(8'h48, 4'hF, 32'hDEAD_BE3A);
    cfg_wr(8'h4C, 4'hF, 32'h1234_5678);
    cfg_wr(8'h50, 4'hF, 32'hCAFE_9ABC);
    cfg_rd_chk(8'h48, "R2 setup dword");
    chk(cfg_rdata == 32'h0000003A, "R2 setup literal", cfg_rdata, 32'h3A);
    cfg_rd_chk(8'h4C, "R2 16-bit dword");
    cfg_rd_chk(8'h50, "R2 8-bit dword");

    // R3: byte enables and unmapped space
    cfg_wr(8'h4C, 4'b0100, 32'hAAAA_AAAA);
    cfg_rd_chk(8'h4C, "R3 single byte enable");
    chk(cfg_rdata == 32'h12AA_5678, "R3 single byte literal", cfg_rdata, 32'h12AA5678);
    cfg_wr(8'h48, 4'b1110, 32'h5555_5555);
    cfg_rd_chk(8'h48, "R3 setup byte0 disabled");
    cfg_wr(8'h50, 4'b1100, 32'h7777_7777);
    cfg_rd_chk(8'h50, "R3 unmapped bytes");
    cfg_wr(8'h5C, 4'hF, 32'h9999_9999);
    cfg_rd_chk(8'h5C, "R3 unmapped address reads zero");
    cfg_rd_chk(8'h48, "R3 unmapped write no effect setup");
    cfg_rd_chk(8'h4C, "R3 unmapped write no effect t16");

    // R4-R8, R10: sweep every count value over all drive/kind combinations
    for (int v = 0; v < 16; v++) begin
      logic [7:0] tb [2][3];
      for (int d = 0; d < 2; d++)
        for (int k = 0; k < 3; k++)
          tb[d][k] = {4'((v + 3*k + 5*d) % 16), 4'((2*v + k + 7*d + 1) % 16)};
      cfg_wr(8'h48, 4'h1, {24'h0, 4'(15 - v), 4'(v)});
      cfg_wr(8'h4C, 4'hF, {tb[1][1], tb[1][0], tb[0][1], tb[0][0]});
      cfg_wr(8'h50, 4'h3, {16'h0, tb[1][2], tb[0][2]});
      for (int c = 0; c < 8; c++) begin
        access(c[0], c[1], c[2], 4'((v * 3 + c) % 16),
               16'(16'hA55A ^ (v * 16'h0101) ^ c), 16'(16'h3CC3 + v * 16'h0111 + c));
      end
    end

    // R9: counts latched at access start despite a rewrite during it
    cfg_wr(8'h48, 4'h1, 32'h0000_0035);
    cfg_wr(8'h4C, 4'hF, 32'h0000_0063);
    mid_on = 1; mid_cyc = 0;
    mid_setup = 32'h0000_0091; mid_taddr = 8'h4C; mid_tval = 32'h0000_0024;
    access(0, 0, 1, 4'h9, 16'h0, 16'hBEEF);
    chk(mid_on == 0 && mid_cyc == 3, "R9 rewrite performed", mid_cyc, 3);
    cfg_rd_chk(8'h48, "R9 rewritten setup");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule